// File: doc/BRIEF.md
# Temperature-Scaled Self-Discharge Counter

This block estimates how much charge a battery loses to self-discharge by counting at a rate that depends on temperature. A periodic time-base pulse (`tick`, one pulse per 1/128 hour) drives the counting. The most recent temperature sample, in signed whole degrees Celsius, picks one of eight 10 °C bands. Each band sets a rate that is a power of two, from one count every eight hours in the coldest band to sixteen counts per hour in the hottest. A fractional accumulator collects the sub-count steps so that no partial count is lost, and its carry advances a 16-bit count. Software reads the count as a high byte and a low byte.

Temperature samples arrive on a valid/ready stream. The block never applies back-pressure: `temp_ready` is held high, and a sample is taken on every cycle in which `temp_valid` is high. `temp_c` is ignored when `temp_valid` is low. There is no separate sleep input. Counting continues for as long as ticks arrive, so the block keeps counting in low-power operation when the time base keeps running. A `clear` pulse zeroes the count and the fractional accumulator.

Top module: `sdc_counter`

## Requirements
- R1: After reset, the count is 0, the fraction is 0 and the selected band is the 20–29 °C band (one count per hour), so 128 ticks with no temperature sample give a count of exactly 1.
- R2: The band index b is 0 for a temperature below 0 °C. For T from 0 °C up to 59 °C it is 1 + floor(T/10), and each band includes its lower edge (exactly 30 °C is in the 2 counts/hour band). Each tick adds 2^b units of 1/1024 count to the fraction, which gives 2^(b-3) counts per hour.
- R3: At 60 °C and above, the rate is held at 16 counts per hour, which is one count per 8 ticks. A 59 °C sample still gives 8 counts per hour.
- R4: Below 0 °C, including the most negative reading (-128), the rate is one count per 1024 ticks.
- R5: Starting from a cleared state at a fixed band, the count after N ticks equals floor(N·2^b/1024) exactly. A single tick never advances the count by more than one.
- R6: The count wraps from its all-ones value to 0 instead of saturating.
- R7: `clear` zeroes the count and the fraction on the next edge. When `clear` and `tick` fall in the same cycle, `clear` wins and that tick is lost.
- R8: In a cycle with neither `tick` nor `clear`, the count does not change.
- R9: `temp_ready` is always 1. A sample accepted in a cycle applies to ticks from the next cycle on, so a tick in the same cycle uses the previous band. `temp_c` has no effect when `temp_valid` is low.
- R10: `cnt_hi` carries the upper half of the count and `cnt_lo` carries the lower half (bits 15:8 and 7:0 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base pulse, one per 1/128 hour |
| temp_valid | input | 1 | Temperature sample valid |
| temp_ready | output | 1 | Sample accepted (always 1) |
| temp_c | input | TEMP_W (8) | Signed temperature in °C |
| clear | input | 1 | Zero the count and the fraction |
| cnt_hi | output | CNT_W-CNT_W/2 (8) | Upper half of the count |
| cnt_lo | output | CNT_W/2 (8) | Lower half of the count |

## Verification
Two kinds of collision can happen in a single cycle. The first is `clear` together with a `tick`. The bench leaves half a count in the fraction at the hottest band, pulses both inputs in one cycle, and then shows that four further ticks give no count while eight give exactly one, which proves the fraction was reset. The second is a temperature sample together with a `tick`. With the fraction four units short of a carry at the coldest band, a 60 °C sample arrives on the same cycle as a tick. The count must stay at 0, because the tick uses the old one-unit step.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int DEF_CNT_W     = 16;
  localparam int DEF_TEMP_W    = 8;
  localparam int DEF_NUM_BANDS = 8;
  localparam int DEF_EDGE_BASE = 0;
  localparam int DEF_EDGE_SPAN = 10;
  localparam int DEF_NOM_BAND  = 3;

  // lower edge in degrees of band k (k >= 1); band 0 is everything below
  function automatic int band_edge(input int k, input int base, input int span);
    return base + (k - 1) * span;
  endfunction
endpackage

// File: rtl/sdc_band_sel.sv
module sdc_band_sel
  import sdc_pkg::*;
#(
  parameter int TEMP_W    = DEF_TEMP_W,
  parameter int NUM_BANDS = DEF_NUM_BANDS,
  parameter int EDGE_BASE = DEF_EDGE_BASE,
  parameter int EDGE_SPAN = DEF_EDGE_SPAN,
  parameter int NOM_BAND  = DEF_NOM_BAND,
  localparam int BAND_W   = $clog2(NUM_BANDS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     temp_valid,
  input  logic signed [TEMP_W-1:0] temp_c,
  output logic [BAND_W-1:0]        band
);
  localparam int NUM_EDGES = NUM_BANDS - 1;

  logic [NUM_EDGES-1:0] at_or_above;
  logic [BAND_W-1:0]    band_d;
  logic [BAND_W-1:0]    band_q;

  // one comparator per band edge; edges rise monotonically
  for (genvar k = 1; k <= NUM_EDGES; k++) begin : g_edge
    assign at_or_above[k-1] = (int'(temp_c) >= band_edge(k, EDGE_BASE, EDGE_SPAN));
  end

  // thermometer code to band index
  always_comb begin
    band_d = '0;
    for (int i = 0; i < NUM_EDGES; i++) begin
      band_d = band_d + BAND_W'(at_or_above[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      band_q <= BAND_W'(NOM_BAND);
    end else if (temp_valid) begin
      band_q <= band_d;
    end
  end

  assign band = band_q;
endmodule

// File: rtl/sdc_rate_acc.sv
module sdc_rate_acc
  import sdc_pkg::*;
#(
  parameter int NUM_BANDS = DEF_NUM_BANDS,
  localparam int BAND_W   = $clog2(NUM_BANDS),
  // largest step is 2^(NUM_BANDS-1) per tick and must give at most 1/8 count per tick
  localparam int FRAC_W   = NUM_BANDS + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              clear,
  input  logic [BAND_W-1:0] band,
  output logic              carry
);
  logic [FRAC_W-1:0] frac_q;
  logic [FRAC_W:0]   step;
  logic [FRAC_W:0]   sum;

  assign step  = (FRAC_W+1)'(1) << band;
  assign sum   = {1'b0, frac_q} + step;
  assign carry = tick & ~clear & sum[FRAC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frac_q <= '0;
    end else if (clear) begin
      frac_q <= '0;
    end else if (tick) begin
      frac_q <= sum[FRAC_W-1:0];
    end
  end
endmodule

// File: rtl/sdc_count_reg.sv
module sdc_count_reg
  import sdc_pkg::*;
#(
  parameter int CNT_W = DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (clear) begin
      count_q <= '0;
    end else if (inc) begin
      count_q <= count_q + CNT_W'(1);   // wraps by width
    end
  end

  assign count = count_q;
endmodule

// File: rtl/sdc_counter.sv
module sdc_counter
  import sdc_pkg::*;
#(
  parameter int CNT_W     = DEF_CNT_W,
  parameter int TEMP_W    = DEF_TEMP_W,
  parameter int NUM_BANDS = DEF_NUM_BANDS,
  parameter int EDGE_BASE = DEF_EDGE_BASE,
  parameter int EDGE_SPAN = DEF_EDGE_SPAN,
  parameter int NOM_BAND  = DEF_NOM_BAND,
  localparam int LO_W     = CNT_W / 2,
  localparam int HI_W     = CNT_W - LO_W,
  localparam int BAND_W   = $clog2(NUM_BANDS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick,
  input  logic                     temp_valid,
  output logic                     temp_ready,
  input  logic signed [TEMP_W-1:0] temp_c,
  input  logic                     clear,
  output logic [HI_W-1:0]          cnt_hi,
  output logic [LO_W-1:0]          cnt_lo
);
  logic [BAND_W-1:0] band_q;
  logic              carry;
  logic [CNT_W-1:0]  count;

  assign temp_ready = 1'b1;

  sdc_band_sel #(
    .TEMP_W(TEMP_W), .NUM_BANDS(NUM_BANDS), .EDGE_BASE(EDGE_BASE),
    .EDGE_SPAN(EDGE_SPAN), .NOM_BAND(NOM_BAND)
  ) u_band (
    .clk(clk), .rst_n(rst_n), .temp_valid(temp_valid),
    .temp_c(temp_c), .band(band_q)
  );

  sdc_rate_acc #(.NUM_BANDS(NUM_BANDS)) u_acc (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clear(clear),
    .band(band_q), .carry(carry)
  );

  sdc_count_reg #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(clear), .inc(carry), .count(count)
  );

  assign cnt_hi = count[CNT_W-1:LO_W];
  assign cnt_lo = count[LO_W-1:0];
endmodule

// File: rtl/sdc_checker.sv
module sdc_checker #(
  parameter int CNT_W     = 16,
  parameter int TEMP_W    = 8,
  parameter int NUM_BANDS = 8,
  parameter int HOT_EDGE  = 60,
  localparam int LO_W     = CNT_W / 2,
  localparam int HI_W     = CNT_W - LO_W,
  localparam int BAND_W   = $clog2(NUM_BANDS)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     tick,
  input logic                     temp_valid,
  input logic signed [TEMP_W-1:0] temp_c,
  input logic                     clear,
  input logic [HI_W-1:0]          cnt_hi,
  input logic [LO_W-1:0]          cnt_lo,
  input logic [BAND_W-1:0]        band
);
  logic [CNT_W-1:0] cnt;
  assign cnt = {cnt_hi, cnt_lo};

  p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> cnt == '0);

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !tick) |=> $stable(cnt));

  // covers wrap too (R6): successor taken modulo the width
  p_single_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clear) |=> (cnt == $past(cnt)) || (cnt == CNT_W'($past(cnt) + 1'b1)));

  p_cold_band_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_valid && (int'(temp_c) < 0)) |=> band == '0);

  p_hot_band_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_valid && (int'(temp_c) >= HOT_EDGE)) |=> band == BAND_W'(NUM_BANDS - 1));

  p_band_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !temp_valid |=> $stable(band));
endmodule

bind sdc_counter sdc_checker #(
  .CNT_W(CNT_W), .TEMP_W(TEMP_W), .NUM_BANDS(NUM_BANDS),
  .HOT_EDGE(EDGE_BASE + (NUM_BANDS - 2) * EDGE_SPAN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .temp_valid(temp_valid),
  .temp_c(temp_c), .clear(clear), .cnt_hi(cnt_hi), .cnt_lo(cnt_lo),
  .band(band_q)
);

// File: tb/sdc_counter_tb.sv
module sdc_counter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic temp_valid = 1'b0;
  logic signed [7:0] temp_c = '0;
  logic clear = 1'b0;
  logic temp_ready, temp_ready8;
  logic [7:0] cnt_hi, cnt_lo;
  logic [3:0] c8_hi, c8_lo;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sdc_counter u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .temp_valid(temp_valid),
    .temp_ready(temp_ready), .temp_c(temp_c), .clear(clear),
    .cnt_hi(cnt_hi), .cnt_lo(cnt_lo)
  );

  // narrow instance so that wrap-around is reachable quickly
  sdc_counter #(.CNT_W(8)) u_dut_w8 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .temp_valid(temp_valid),
    .temp_ready(temp_ready8), .temp_c(temp_c), .clear(clear),
    .cnt_hi(c8_hi), .cnt_lo(c8_lo)
  );

  // vectors: temperature, ticks from cleared state, expected count
  localparam int NV = 18;
  localparam int V_TEMP [NV] = '{-40, -40,   0,    5,   9,  10,  25,  29, 30, 30,
                                  45,  55,  59,   60, 100, -128, 127, 100};
  localparam int V_TICK [NV] = '{1023, 1024, 512, 1023, 511, 256, 128, 384, 64, 63,
                                  32,  160,   16,    8,  80, 2048,   7, 4000};
  localparam int V_EXP  [NV] = '{0, 1, 1, 1, 0, 1, 1, 3, 1, 0,
                                  1, 10, 1, 1, 10, 2, 0, 500};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int cnt16();
    return {cnt_hi, cnt_lo};
  endfunction

  task automatic do_ticks(input int n);
    if (n > 0) begin
      @(negedge clk) tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic do_clear();
    @(negedge clk) clear = 1'b1;
    @(negedge clk) clear = 1'b0;
  endtask

  task automatic set_temp(input int t);
    @(negedge clk) begin temp_valid = 1'b1; temp_c = 8'(t); end
    @(negedge clk) temp_valid = 1'b0;
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state and nominal band
    chk("R1 reset count", cnt16(), 0);
    chk("R9 ready", int'(temp_ready), 1);
    do_ticks(127);
    chk("R1 nominal 127 ticks", cnt16(), 0);
    do_ticks(1);
    chk("R1 nominal 128 ticks", cnt16(), 1);

    // R2 R3 R4 R5 R10 table walk
    for (int i = 0; i < NV; i++) begin
      do_clear();
      set_temp(V_TEMP[i]);
      do_ticks(V_TICK[i]);
      chk($sformatf("R2/R5 vec %0d T=%0d", i, V_TEMP[i]), cnt16(), V_EXP[i]);
    end
    // last vector left 500: check byte split R10
    chk("R10 high byte", int'(cnt_hi), 1);
    chk("R10 low byte", int'(cnt_lo), 244);

    // R8: idle cycles keep the count
    held = cnt16();
    repeat (20) @(negedge clk);
    chk("R8 idle hold", cnt16(), held);

    // R9: temp_c ignored without valid
    do_clear();
    set_temp(25);
    @(negedge clk) temp_c = 8'sd60;
    do_ticks(128);
    chk("R9 ignored temp_c", cnt16(), 1);

    // R9: sample and tick in the same cycle -> old band for that tick
    do_clear();
    set_temp(-5);
    do_ticks(1020);
    @(negedge clk) begin tick = 1'b1; temp_valid = 1'b1; temp_c = 8'sd60; end
    @(negedge clk) begin tick = 1'b0; temp_valid = 1'b0; end
    chk("R9 same-cycle old band", cnt16(), 0);
    do_ticks(1);
    chk("R9 new band next tick", cnt16(), 1);

    // R7: clear and tick together, fraction also cleared
    do_clear();
    set_temp(60);
    do_ticks(12);
    chk("R7 pre-clear", cnt16(), 1);
    @(negedge clk) begin clear = 1'b1; tick = 1'b1; end
    @(negedge clk) begin clear = 1'b0; tick = 1'b0; end
    chk("R7 clear wins", cnt16(), 0);
    do_ticks(4);
    chk("R7 fraction cleared", cnt16(), 0);
    do_ticks(4);
    chk("R7 count after clear", cnt16(), 1);

    // R6: wrap on the 8-bit instance (one count per 8 ticks)
    do_clear();
    set_temp(60);
    do_ticks(2040);
    chk("R6 narrow at max", int'({c8_hi, c8_lo}), 255);
    do_ticks(8);
    chk("R6 wrap to zero", int'({c8_hi, c8_lo}), 0);
    do_ticks(8);
    chk("R6 after wrap", int'({c8_hi, c8_lo}), 1);

    report();
  end
endmodule